// File: doc/BRIEF.md
# Received Pause Frame Flow Controller

This block sits beside a MAC's receive and transmit paths and handles IEEE 802.3x flow control. It watches the received byte stream for frames whose type is the MAC control type and whose opcode is PAUSE. It loads the 16-bit pause time and counts it down in quanta. While the count is running it inhibits the start of new transmissions. A frame that is already on the wire when the pause arrives is allowed to finish. Transmission resumes by itself once the count reaches zero.

In the other direction, the block watches the receive FIFO occupancy. When the occupancy climbs to a programmable threshold, it asks the transmit side to send an outgoing pause frame. Honouring received pause frames and generating new ones have separate enables. A further control input lets pause frames be accepted whatever their destination address. One quantum is `QUANTUM_CYC` clock cycles; the default of 64 matches 512 bit times on a byte-per-cycle stream.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A frame counts as a pause frame only when all of these hold: bytes 0..5 (first byte first) are 01 80 C2 00 00 01, bytes 12..13 are 88 08, and bytes 14..15 are 00 01. The pause time is then bytes 16..17, most significant byte first.
- R2: A pause frame is acted on only at its end-of-frame strobe with `rx_good_i` high, and only if it held at least 18 bytes. A frame that ends with `rx_good_i` low changes nothing.
- R3: With `any_da_i` high, a frame that matches R1 in everything except the destination address is still acted on.
- R4: With `rx_honor_en_i` low, received pause frames have no effect on `pause_led_o` or `tx_hold_o`.
- R5: For an accepted pause time T > 0, `pause_led_o` is high from the second clock edge after the end-of-frame strobe. It stays high for exactly T*QUANTUM_CYC cycles and then falls on its own.
- R6: `tx_hold_o` is never raised on an edge where `tx_busy_i` is high. It rises on the first edge with `tx_busy_i` low while the pause is running, and it is only ever high while `pause_led_o` is high.
- R7: An accepted pause time of zero clears `pause_led_o` and `tx_hold_o` on the same edge where a nonzero time would have loaded.
- R8: A pause frame accepted while a pause is running restarts the count with the new time. The new time is measured from its own load edge.
- R9: With `tx_gen_en_i` high, `pause_req_o` pulses high for exactly one cycle. The pulse follows the edge where `fifo_level_i >= xoff_thresh_i` first becomes true after having been false.
- R10: With `tx_gen_en_i` low, `pause_req_o` stays low whatever the FIFO level does.
- R11: After reset, `tx_hold_o`, `pause_req_o` and `pause_led_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | DATA_W | Received byte |
| rx_eof_i | input | 1 | End-of-frame strobe, carries no byte |
| rx_good_i | input | 1 | Frame status; sampled with `rx_eof_i` |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| fifo_level_i | input | LVL_W | Receive FIFO occupancy |
| xoff_thresh_i | input | LVL_W | Occupancy at which a pause request is raised |
| rx_honor_en_i | input | 1 | Act on received pause frames |
| tx_gen_en_i | input | 1 | Allow outgoing pause requests |
| any_da_i | input | 1 | Accept pause frames with any destination address |
| tx_hold_o | output | 1 | Inhibit start of a new transmit frame |
| pause_req_o | output | 1 | One-cycle request to send a pause frame |
| pause_led_o | output | 1 | Pause timer running |

## Verification
The bench targets the exact length of the pause window. An off-by-one prescaler or count would hold `pause_led_o` one cycle or one quantum too long or too short.

It raises `tx_busy_i` across a pause. A design that gated at once would cut a frame short by asserting `tx_hold_o` while busy.

It sends a zero pause time into a running pause and a second time mid-pause. A design that ignored zero would stay paused, and one that added the times would expire late.

Corrupted type, opcode, address, bad status and disabled honouring all must leave the outputs idle. Threshold tests check that the request is a single edge-triggered pulse rather than a level.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned HDR_BYTES = 18;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OP  = 16'h0001;

  function automatic logic [7:0] resv_da_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h01;
      3'd1: return 8'h80;
      3'd2: return 8'hC2;
      3'd5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pfc_rx_parser.sv
module pfc_rx_parser
  import pfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_eof_i,
  input  logic              rx_good_i,
  input  logic              any_da_i,
  output logic              pause_vld_o,
  output logic [TIME_W-1:0] pause_time_o
);
  localparam int unsigned CNT_W = $clog2(HDR_BYTES) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  byte_cnt_q;
  logic              da_ok_q, type_ok_q, op_ok_q;
  logic [TIME_W-1:0] time_q;
  logic [7:0]        rx_byte;

  assign rx_byte = rx_data_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt_q   <= '0;
      da_ok_q      <= 1'b1;
      type_ok_q    <= 1'b1;
      op_ok_q      <= 1'b1;
      time_q       <= '0;
      pause_vld_o  <= 1'b0;
      pause_time_o <= '0;
    end else begin
      pause_vld_o <= 1'b0;
      if (rx_eof_i) begin
        pause_vld_o  <= rx_good_i && (da_ok_q || any_da_i) && type_ok_q && op_ok_q &&
                        (byte_cnt_q >= CNT_W'(HDR_BYTES));
        pause_time_o <= time_q;
        byte_cnt_q   <= '0;
        da_ok_q      <= 1'b1;
        type_ok_q    <= 1'b1;
        op_ok_q      <= 1'b1;
      end else if (rx_valid_i) begin
        if (byte_cnt_q != CNT_MAX) byte_cnt_q <= byte_cnt_q + 1'b1;
        if (byte_cnt_q < CNT_W'(6)) begin
          if (rx_byte != resv_da_byte(byte_cnt_q[2:0])) da_ok_q <= 1'b0;
        end
        case (byte_cnt_q)
          CNT_W'(12): if (rx_byte != CTRL_TYPE[15:8]) type_ok_q <= 1'b0;
          CNT_W'(13): if (rx_byte != CTRL_TYPE[7:0])  type_ok_q <= 1'b0;
          CNT_W'(14): if (rx_byte != PAUSE_OP[15:8])  op_ok_q   <= 1'b0;
          CNT_W'(15): if (rx_byte != PAUSE_OP[7:0])   op_ok_q   <= 1'b0;
          CNT_W'(16): time_q <= {rx_byte, time_q[7:0]};
          CNT_W'(17): time_q <= {time_q[TIME_W-1:8], rx_byte};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer #(
  parameter int unsigned TIME_W      = 16,
  parameter int unsigned QUANTUM_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              honor_en_i,
  input  logic              tx_busy_i,
  output logic              active_o,
  output logic              hold_o
);
  localparam int unsigned PRE_W = (QUANTUM_CYC > 1) ? $clog2(QUANTUM_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(QUANTUM_CYC - 1);

  logic [TIME_W-1:0] quanta_q, quanta_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              hold_q, hold_d;

  always_comb begin
    quanta_d = quanta_q;
    pre_d    = pre_q;
    if (load_i && honor_en_i) begin
      quanta_d = time_i;
      pre_d    = '0;
    end else if (quanta_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_d    = '0;
        quanta_d = quanta_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    // let an in-flight frame finish before gating
    hold_d = (quanta_d != '0) && (hold_q || !tx_busy_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quanta_q <= '0;
      pre_q    <= '0;
      hold_q   <= 1'b0;
    end else begin
      quanta_q <= quanta_d;
      pre_q    <= pre_d;
      hold_q   <= hold_d;
    end
  end

  assign active_o = (quanta_q != '0);
  assign hold_o   = hold_q;
endmodule

// File: rtl/pfc_xoff_gen.sv
module pfc_xoff_gen #(
  parameter int unsigned LVL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             req_o
);
  logic above, above_q;

  assign above = (level_i >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      above_q <= above;
      req_o   <= gen_en_i && above && !above_q;
    end
  end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TIME_W      = 16,
  parameter int unsigned LVL_W       = 12,
  parameter int unsigned QUANTUM_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_eof_i,
  input  logic              rx_good_i,
  input  logic              tx_busy_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [LVL_W-1:0]  xoff_thresh_i,
  input  logic              rx_honor_en_i,
  input  logic              tx_gen_en_i,
  input  logic              any_da_i,
  output logic              tx_hold_o,
  output logic              pause_req_o,
  output logic              pause_led_o
);
  logic              pause_vld;
  logic [TIME_W-1:0] pause_time;

  pfc_rx_parser #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_parser (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_eof_i, .rx_good_i, .any_da_i,
    .pause_vld_o(pause_vld), .pause_time_o(pause_time)
  );

  pfc_pause_timer #(.TIME_W(TIME_W), .QUANTUM_CYC(QUANTUM_CYC)) u_timer (
    .clk_i, .rst_ni, .load_i(pause_vld), .time_i(pause_time),
    .honor_en_i(rx_honor_en_i), .tx_busy_i,
    .active_o(pause_led_o), .hold_o(tx_hold_o)
  );

  pfc_xoff_gen #(.LVL_W(LVL_W)) u_xoff (
    .clk_i, .rst_ni, .gen_en_i(tx_gen_en_i), .level_i(fifo_level_i),
    .thresh_i(xoff_thresh_i), .req_o(pause_req_o)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_busy_i,
  input logic rx_honor_en_i,
  input logic tx_gen_en_i,
  input logic tx_hold_o,
  input logic pause_req_o,
  input logic pause_led_o
);
  assert_hold_needs_pause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hold_o |-> pause_led_o);

  assert_hold_waits_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_hold_o) |-> !$past(tx_busy_i));

  assert_pause_needs_honor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_led_o) |-> $past(rx_honor_en_i));

  assert_req_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |=> !pause_req_o);

  assert_req_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |-> $past(tx_gen_en_i));
endmodule

bind pause_flow_ctrl pfc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_busy_i(tx_busy_i), .rx_honor_en_i(rx_honor_en_i),
  .tx_gen_en_i(tx_gen_en_i), .tx_hold_o(tx_hold_o), .pause_req_o(pause_req_o),
  .pause_led_o(pause_led_o)
);

// File: tb/pause_flow_ctrl_tb.sv
`timescale 1ns/1ps
module pause_flow_ctrl_tb;
  localparam int Q = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 0, rx_eof_i = 0, rx_good_i = 0, tx_busy_i = 0;
  logic [7:0] rx_data_i = '0;
  logic [11:0] fifo_level_i = '0, xoff_thresh_i = 12'd100;
  logic rx_honor_en_i = 1, tx_gen_en_i = 1, any_da_i = 0;
  logic tx_hold_o, pause_req_o, pause_led_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  pause_flow_ctrl #(.QUANTUM_CYC(Q)) u_dut (.*);

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit accepts(bit da_ok, bit anyda, logic [15:0] typ, logic [15:0] op,
                                 bit good, bit honor, int len);
    return honor && good && (da_ok || anyda) && typ == 16'h8808 && op == 16'h0001 && len >= 18;
  endfunction

  // returns at the negedge after the load edge
  task automatic send(input bit da_ok, input logic [15:0] typ, input logic [15:0] op,
                      input logic [15:0] t, input bit good, input int pad, input int len_cut = 0);
    logic [7:0] b;
    for (int i = 0; i < 18 + pad - len_cut; i++) begin
      case (i)
        0: b = 8'h01; 1: b = 8'h80; 2: b = 8'hC2; 3: b = 8'h00; 4: b = 8'h00;
        5: b = da_ok ? 8'h01 : 8'h02;
        12: b = typ[15:8]; 13: b = typ[7:0];
        14: b = op[15:8];  15: b = op[7:0];
        16: b = t[15:8];   17: b = t[7:0];
        default: b = 8'($urandom);
      endcase
      rx_valid_i = 1; rx_data_i = b;
      @(negedge clk_i);
    end
    rx_valid_i = 0; rx_eof_i = 1; rx_good_i = good;
    @(negedge clk_i);
    rx_eof_i = 0; rx_good_i = 0;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2);
    check(tx_hold_o, 0, "R11 hold");
    check(pause_req_o, 0, "R11 req");
    check(pause_led_o, 0, "R11 led");
    rst_ni = 1; idle(2);

    // R1/R5: valid pause, exact duration
    send(1, 16'h8808, 16'h0001, 16'd3, 1, 0);
    check(pause_led_o, 1, "R1 led after valid frame");
    check(tx_hold_o, 1, "R6 hold when idle tx");
    idle(3*Q - 1);
    check(pause_led_o, 1, "R5 led last cycle");
    idle(1);
    check(pause_led_o, 0, "R5 led expired");
    check(tx_hold_o, 0, "R5 hold expired");

    // R2: bad status, short frame
    send(1, 16'h8808, 16'h0001, 16'd3, 0, 0);
    check(pause_led_o, 0, "R2 bad frame ignored");
    send(1, 16'h8808, 16'h0001, 16'd3, 1, 0, 1);
    check(pause_led_o, 0, "R2 short frame ignored");
    // R1 wrong fields
    send(1, 16'h0800, 16'h0001, 16'd3, 1, 2);
    check(pause_led_o, 0, "R1 wrong type");
    send(1, 16'h8808, 16'h0002, 16'd3, 1, 2);
    check(pause_led_o, 0, "R1 wrong opcode");
    send(0, 16'h8808, 16'h0001, 16'd3, 1, 2);
    check(pause_led_o, 0, "R1 wrong DA");
    // R3
    any_da_i = 1;
    send(0, 16'h8808, 16'h0001, 16'd1, 1, 2);
    check(pause_led_o, 1, "R3 any DA accepted");
    any_da_i = 0; idle(Q + 1);
    // R4
    rx_honor_en_i = 0;
    send(1, 16'h8808, 16'h0001, 16'd3, 1, 0);
    check(pause_led_o, 0, "R4 led ignored");
    check(tx_hold_o, 0, "R4 hold ignored");
    rx_honor_en_i = 1;

    // R6: busy defers hold
    tx_busy_i = 1;
    send(1, 16'h8808, 16'h0001, 16'd20, 1, 0);
    check(pause_led_o, 1, "R6 led while busy");
    check(tx_hold_o, 0, "R6 hold deferred");
    idle(2);
    check(tx_hold_o, 0, "R6 still deferred");
    tx_busy_i = 0; idle(1);
    check(tx_hold_o, 1, "R6 hold after frame");
    tx_busy_i = 1; idle(1);
    check(tx_hold_o, 1, "R6 hold kept once set");
    tx_busy_i = 0;
    // R8: reload
    send(1, 16'h8808, 16'h0001, 16'd2, 1, 0);
    idle(2*Q - 1);
    check(pause_led_o, 1, "R8 reload last cycle");
    idle(1);
    check(pause_led_o, 0, "R8 reload expired");
    // R7: zero cancels
    send(1, 16'h8808, 16'h0001, 16'd50, 1, 0);
    check(tx_hold_o, 1, "R7 paused before cancel");
    send(1, 16'h8808, 16'h0001, 16'd0, 1, 0);
    check(pause_led_o, 0, "R7 led cancelled");
    check(tx_hold_o, 0, "R7 hold cancelled");

    // R9/R10
    fifo_level_i = 12'd50; idle(2);
    check(pause_req_o, 0, "R9 below threshold");
    fifo_level_i = 12'd100; idle(1);
    check(pause_req_o, 1, "R9 pulse at threshold");
    idle(1);
    check(pause_req_o, 0, "R9 single pulse");
    fifo_level_i = 12'd200; idle(1);
    check(pause_req_o, 0, "R9 no repeat above");
    tx_gen_en_i = 0; fifo_level_i = 12'd10; idle(1);
    fifo_level_i = 12'd150; idle(1);
    check(pause_req_o, 0, "R10 disabled crossing");
    idle(1);
    check(pause_req_o, 0, "R10 disabled later");
    tx_gen_en_i = 1; fifo_level_i = 12'd0; idle(1);

    // random frames
    for (int it = 0; it < 40; it++) begin
      bit da_ok, anyd, good; logic [15:0] typ, op, t; int pad; bit exp;
      for (int w = 0; w < 4*Q && pause_led_o; w++) idle(1);
      da_ok = ($urandom % 4) != 0; anyd = ($urandom % 5) == 0;
      typ = (($urandom % 4) != 0) ? 16'h8808 : 16'h8100;
      op  = (($urandom % 4) != 0) ? 16'h0001 : 16'h0101;
      good = ($urandom % 5) != 0; t = 16'($urandom % 3); pad = $urandom % 4;
      any_da_i = anyd;
      send(da_ok, typ, op, t, good, pad);
      exp = accepts(da_ok, anyd, typ, op, good, 1, 18 + pad) && t != 0;
      check(pause_led_o, exp, "R1 random led");
      check(tx_hold_o, exp, "R2 random hold");
    end
    summary();
  end
endmodule